// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits in a host bridge's address path and classifies every memory access that falls in the 640 KB to 1 MB legacy window. For each address it chooses one of three targets: system DRAM, the legacy expansion bus (forward), or a write-ignore. A write is ignored when it hits a segment that is mapped as read-only DRAM.

The 0xC0000–0xFFFFF range is split into twelve 16 KB segments and one 64 KB top segment. Each segment carries a 2-bit attribute, and these attributes are packed as nibbles into a small bank of byte-wide configuration registers. The 0xA0000–0xBFFFF video window is handled separately. Its mapping is set by a system-management RAM control byte together with the system-management-mode input.

The configuration bank is written through a byte write port. The access decode is combinational from the registered configuration, the access address, the write flag and the mode input.

Top module: `legacy_map_decoder`

## Requirements
- R1: After reset every attribute byte is 0x00 and the SMRAM control byte is 0x02. All of 0xA0000–0xFFFFF then decodes as forward, whatever the values of smm_i and acc_we_i.
- R2: An address below 0xA0000 or at or above 0x100000 always decodes as DRAM (tgt_o = 2'b00).
- R3: A segment with attribute 3 decodes as DRAM (2'b00) for both reads and writes.
- R4: A segment with attribute 1 decodes a read as DRAM (2'b00) and a write as write-ignore (2'b10).
- R5: A segment with attribute 0 or 2 decodes as forward (2'b01) for reads and writes. Forward never appears outside 0xA0000–0xFFFFF, and tgt_o never takes the value 2'b11.
- R6: The 16 KB segment i (i = 0..11, base 0xC0000 + i*0x4000) takes its attribute from config offset 0x5A + (i>>1). Even i uses bits [1:0] and odd i uses bits [5:4]. Bits [3:2] and [7:6] have no effect.
- R7: The segment 0xF0000–0xFFFFF takes its attribute from bits [5:4] of config offset 0x59. The other bits of that byte have no effect.
- R8: The window 0xA0000–0xBFFFF decodes as DRAM when bit 6 of config offset 0x72 is set, or when smm_i is high and bit 3 of 0x72 is set. Otherwise it decodes as forward. A change of smm_i takes effect in the same cycle.
- R9: A config write lands at the clock edge. An access presented in the same cycle as the write is decoded with the old value, and accesses in later cycles use the new value.
- R10: Writes to any offset other than 0x59–0x5F and 0x72 change no decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config byte write strobe |
| cfg_addr_i | input | 8 | Config byte offset |
| cfg_wdata_i | input | 8 | Config write data |
| smm_i | input | 1 | System-management mode active |
| acc_addr_i | input | 32 | Access address |
| acc_we_i | input | 1 | Access is a write |
| tgt_o | output | 2 | Target: 00 DRAM, 01 forward, 10 write-ignore |

## Verification
A config write and an access to the segment that the write remaps can fall in the same cycle. So can a toggle of smm_i and an access to the video window. The bench provokes the first collision on purpose: it rewrites a segment's attribute byte while it accesses that segment, and expects the old attribute in that cycle and the new one in the next. The second collision is provoked by flipping smm_i on every cycle while video accesses continue, and the bench expects the decode to follow the mode at once. A behavioural reference updates its own config image only after the edge and judges every cycle, including a long stretch of mixed random writes and accesses.

// File: rtl/lmap_pkg.sv
package lmap_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM = 2'b00,
    TGT_FWD  = 2'b01,
    TGT_WIGN = 2'b10
  } tgt_e;

  typedef enum logic [1:0] {
    RGN_OUT   = 2'b00,
    RGN_VIDEO = 2'b01,
    RGN_SEG   = 2'b10,
    RGN_TOP   = 2'b11
  } rgn_e;

  localparam logic [1:0] ATTR_RW = 2'd3;
  localparam logic [1:0] ATTR_RO = 2'd1;
endpackage

// File: rtl/lmap_cfg_regs.sv
module lmap_cfg_regs #(
  parameter int          CFG_AW    = 8,
  parameter int          NUM_BYTES = 7,
  parameter logic [7:0]  ATTR_BASE = 8'h59,
  parameter logic [7:0]  SMRAM_OFS = 8'h72,
  parameter logic [7:0]  SMRAM_RST = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        attr_bytes_o [NUM_BYTES],
  output logic [7:0]        smram_o
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_attr
    localparam logic [CFG_AW-1:0] OFS = CFG_AW'(ATTR_BASE) + CFG_AW'(b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   attr_bytes_o[b] <= 8'h00;
      else if (we_i && addr_i == OFS) attr_bytes_o[b] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     smram_o <= SMRAM_RST;
    else if (we_i && addr_i == CFG_AW'(SMRAM_OFS))   smram_o <= wdata_i;
  end
endmodule

// File: rtl/lmap_seg_lookup.sv
module lmap_seg_lookup
  import lmap_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              NUM_SEG   = 12,
  parameter int              SEG_SHIFT = 14,
  parameter logic [31:0]     VID_BASE  = 32'h000A_0000,
  parameter logic [31:0]     SEG_BASE  = 32'h000C_0000,
  parameter logic [31:0]     TOP_BASE  = 32'h000F_0000,
  parameter logic [31:0]     WIN_END   = 32'h0010_0000,
  localparam int             SEG_IW    = $clog2(NUM_SEG)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rgn_e              rgn_o,
  output logic [SEG_IW-1:0] seg_idx_o
);
  logic [ADDR_W-1:0] seg_off;

  assign seg_off   = addr_i - ADDR_W'(SEG_BASE);
  assign seg_idx_o = seg_off[SEG_SHIFT +: SEG_IW];

  always_comb begin
    if (addr_i < ADDR_W'(VID_BASE) || addr_i >= ADDR_W'(WIN_END)) rgn_o = RGN_OUT;
    else if (addr_i < ADDR_W'(SEG_BASE))                          rgn_o = RGN_VIDEO;
    else if (addr_i < ADDR_W'(TOP_BASE))                          rgn_o = RGN_SEG;
    else                                                          rgn_o = RGN_TOP;
  end
endmodule

// File: rtl/lmap_attr_select.sv
module lmap_attr_select #(
  parameter int  NUM_SEG   = 12,
  parameter int  TOP_LSB   = 4,
  localparam int NUM_BYTES = 1 + (NUM_SEG + 1) / 2,
  localparam int SEG_IW    = $clog2(NUM_SEG)
) (
  input  logic [7:0]        attr_bytes_i [NUM_BYTES],
  input  logic [SEG_IW-1:0] seg_idx_i,
  output logic [1:0]        seg_attr_o,
  output logic [1:0]        top_attr_o
);
  logic [1:0] seg_attr [NUM_SEG];

  // byte 0 holds the top segment; segments pack two per byte from byte 1
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam int BYTE = 1 + s / 2;
    localparam int LSB  = (s % 2) * 4;
    assign seg_attr[s] = attr_bytes_i[BYTE][LSB +: 2];
  end

  assign top_attr_o = attr_bytes_i[0][TOP_LSB +: 2];
  assign seg_attr_o = (int'(seg_idx_i) < NUM_SEG) ? seg_attr[seg_idx_i] : 2'b00;
endmodule

// File: rtl/lmap_resolve.sv
module lmap_resolve
  import lmap_pkg::*;
#(
  parameter int OPEN_BIT = 6,
  parameter int SMM_BIT  = 3
) (
  input  rgn_e       rgn_i,
  input  logic [1:0] seg_attr_i,
  input  logic [1:0] top_attr_i,
  input  logic       we_i,
  input  logic       smm_i,
  input  logic [7:0] smram_i,
  output tgt_e       tgt_o
);
  logic [1:0] attr;
  logic       vid_dram;

  assign attr     = (rgn_i == RGN_TOP) ? top_attr_i : seg_attr_i;
  assign vid_dram = smram_i[OPEN_BIT] | (smm_i & smram_i[SMM_BIT]);

  always_comb begin
    unique case (rgn_i)
      RGN_OUT:   tgt_o = TGT_DRAM;
      RGN_VIDEO: tgt_o = vid_dram ? TGT_DRAM : TGT_FWD;
      default: begin
        if (attr == ATTR_RW)      tgt_o = TGT_DRAM;
        else if (attr == ATTR_RO) tgt_o = we_i ? TGT_WIGN : TGT_DRAM;
        else                      tgt_o = TGT_FWD;
      end
    endcase
  end
endmodule

// File: rtl/legacy_map_decoder.sv
module legacy_map_decoder
  import lmap_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          CFG_AW    = 8,
  parameter int          NUM_SEG   = 12,
  parameter int          SEG_SHIFT = 14,
  parameter logic [7:0]  ATTR_BASE = 8'h59,
  parameter logic [7:0]  SMRAM_OFS = 8'h72,
  parameter logic [7:0]  SMRAM_RST = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              smm_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_we_i,
  output logic [1:0]        tgt_o
);
  localparam int NUM_BYTES = 1 + (NUM_SEG + 1) / 2;
  localparam int SEG_IW    = $clog2(NUM_SEG);

  logic [7:0]        attr_bytes [NUM_BYTES];
  logic [7:0]        smram_q;
  rgn_e              rgn;
  logic [SEG_IW-1:0] seg_idx;
  logic [1:0]        seg_attr, top_attr;
  tgt_e              tgt;

  lmap_cfg_regs #(
    .CFG_AW(CFG_AW), .NUM_BYTES(NUM_BYTES), .ATTR_BASE(ATTR_BASE),
    .SMRAM_OFS(SMRAM_OFS), .SMRAM_RST(SMRAM_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .attr_bytes_o(attr_bytes), .smram_o(smram_q)
  );

  lmap_seg_lookup #(
    .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .SEG_SHIFT(SEG_SHIFT)
  ) u_lookup (
    .addr_i(acc_addr_i), .rgn_o(rgn), .seg_idx_o(seg_idx)
  );

  lmap_attr_select #(.NUM_SEG(NUM_SEG)) u_sel (
    .attr_bytes_i(attr_bytes), .seg_idx_i(seg_idx),
    .seg_attr_o(seg_attr), .top_attr_o(top_attr)
  );

  lmap_resolve u_res (
    .rgn_i(rgn), .seg_attr_i(seg_attr), .top_attr_i(top_attr),
    .we_i(acc_we_i), .smm_i(smm_i), .smram_i(smram_q), .tgt_o(tgt)
  );

  assign tgt_o = tgt;
endmodule

// File: rtl/lmap_checker.sv
module lmap_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [7:0]  cfg_addr_i,
  input logic [7:0]  cfg_wdata_i,
  input logic        smm_i,
  input logic [31:0] acc_addr_i,
  input logic        acc_we_i,
  input logic [1:0]  tgt_o,
  input logic [7:0]  smram_i
);
  logic in_win, in_vid;
  assign in_win = acc_addr_i >= 32'h000A_0000 && acc_addr_i < 32'h0010_0000;
  assign in_vid = acc_addr_i >= 32'h000A_0000 && acc_addr_i < 32'h000C_0000;

  p_outside_dram_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> tgt_o == 2'b00);

  p_read_no_wign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_we_i |-> tgt_o != 2'b10);

  p_fwd_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_o == 2'b01 |-> in_win);

  p_no_illegal_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_o != 2'b11);

  p_video_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_vid && !smram_i[6] && !(smm_i && smram_i[3])) |-> tgt_o == 2'b01);

  p_video_open_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_vid && smm_i && smram_i[3]) |-> tgt_o == 2'b00);

  p_open_write_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 8'h72 && cfg_wdata_i[6]) |=> (!in_vid || tgt_o == 2'b00));
endmodule

bind legacy_map_decoder lmap_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i), .smm_i(smm_i), .acc_addr_i(acc_addr_i),
  .acc_we_i(acc_we_i), .tgt_o(tgt_o), .smram_i(smram_q)
);

// File: tb/tb_legacy_map_decoder.sv
module tb_legacy_map_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        smm = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_we = 1'b0;
  logic [1:0]  tgt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] mcfg [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_map_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .smm_i(smm), .acc_addr_i(acc_addr),
    .acc_we_i(acc_we), .tgt_o(tgt)
  );

  function automatic logic [1:0] attr_to_tgt(input int attr, input logic we);
    if (attr == 3) return 2'b00;
    if (attr == 1) return we ? 2'b10 : 2'b00;
    return 2'b01;
  endfunction

  function automatic logic [1:0] ref_tgt(input logic [31:0] a, input logic we, input logic s);
    int seg;
    int b;
    if (a < 32'hA0000 || a >= 32'h100000) return 2'b00;
    if (a < 32'hC0000) begin
      if (mcfg[8'h72][6] || (s && mcfg[8'h72][3])) return 2'b00;
      return 2'b01;
    end
    if (a >= 32'hF0000) return attr_to_tgt(int'(mcfg[8'h59] / 16) % 4, we);
    seg = int'((a - 32'hC0000) / 32'h4000);
    b   = int'(mcfg[8'h5A + 8'(seg / 2)]);
    if (seg % 2 == 1) return attr_to_tgt((b / 16) % 4, we);
    return attr_to_tgt(b % 4, we);
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if ((a >= 8'h59 && a <= 8'h5F) || a == 8'h72) mcfg[a] = d;
  endtask

  task automatic cyc(input logic [31:0] a, input logic we, input logic s,
                     input logic cw, input logic [7:0] ca, input logic [7:0] cd,
                     input string req);
    logic [1:0] exp;
    @(negedge clk);
    acc_addr = a; acc_we = we; smm = s;
    cfg_we = cw; cfg_addr = ca; cfg_wdata = cd;
    #1;
    exp = ref_tgt(a, we, s);
    checks++;
    if (tgt !== exp) begin
      fails++;
      $display("FAIL %s addr=%h we=%0b smm=%0b actual=%b expected=%b", req, a, we, s, tgt, exp);
    end
    @(posedge clk);
    if (cw) model_write(ca, cd);
    #1 cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input logic we, input logic s, input string req);
    cyc(a, we, s, 1'b0, 8'h00, 8'h00, req);
  endtask

  task automatic wr(input logic [7:0] ca, input logic [7:0] cd, input string req);
    cyc(32'h0, 1'b0, 1'b0, 1'b1, ca, cd, req);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 12; i++) begin
      acc(32'hC0000 + i * 32'h4000, 1'b0, 1'b0, req);
      acc(32'hC0000 + i * 32'h4000 + 32'h3FFF, 1'b1, 1'b0, req);
    end
    acc(32'hF0000, 1'b0, 1'b0, req);
    acc(32'hFFFFF, 1'b1, 1'b0, req);
    acc(32'hA0000, 1'b0, 1'b0, req);
    acc(32'hBFFFF, 1'b1, 1'b1, req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mcfg[i] = 8'h00;
    mcfg[8'h72] = 8'h02;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, both modes and directions
    for (int i = 0; i < 4; i++) begin
      sweep("R1 reset");
      acc(32'hB0000, i[0], i[1], "R1 reset video");
    end

    // R2: outside the window
    acc(32'h0, 1'b0, 1'b0, "R2");
    acc(32'h9FFFF, 1'b1, 1'b1, "R2");
    acc(32'h100000, 1'b1, 1'b0, "R2");
    acc(32'hFFFFFFFF, 1'b0, 1'b1, "R2");

    // R3 R4 R6: segment nibble packing, upper nibble bits ignored
    wr(8'h5A, 8'h13, "R6");
    acc(32'hC0000, 1'b0, 1'b0, "R3 read");
    acc(32'hC0000, 1'b1, 1'b0, "R3 write");
    acc(32'hC4000, 1'b0, 1'b0, "R4 read");
    acc(32'hC4000, 1'b1, 1'b0, "R4 write");
    wr(8'h5B, 8'hC2, "R6");
    wr(8'h5C, 8'h7B, "R6");
    wr(8'h5D, 8'h31, "R6");
    wr(8'h5E, 8'h1E, "R6");
    wr(8'h5F, 8'hD3, "R6");
    sweep("R6 pattern");
    acc(32'hC8000, 1'b1, 1'b0, "R5 attr2");
    acc(32'hCC000, 1'b0, 1'b0, "R5 attr0");

    // R7: top segment
    wr(8'h59, 8'hCF, "R7");
    acc(32'hF8000, 1'b0, 1'b0, "R7 low bits ignored");
    wr(8'h59, 8'h30, "R7");
    acc(32'hF0000, 1'b1, 1'b0, "R7 rw");
    wr(8'h59, 8'h10, "R7");
    acc(32'hFFFFF, 1'b1, 1'b0, "R7 ro write");
    acc(32'hFFFFF, 1'b0, 1'b0, "R7 ro read");

    // R8: video window, mode toggling every cycle
    wr(8'h72, 8'h08, "R8");
    for (int i = 0; i < 8; i++) acc(32'hA0000 + i * 32'h4000, i[0], i[0], "R8 smm toggle");
    wr(8'h72, 8'h40, "R8");
    for (int i = 0; i < 4; i++) acc(32'hBFFF0, i[0], i[1], "R8 open");
    wr(8'h72, 8'h00, "R8");
    acc(32'hA0000, 1'b0, 1'b1, "R8 closed");

    // R9: write and access to the same segment in the same cycle
    cyc(32'hC0000, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h01, "R9 same cycle");
    acc(32'hC0000, 1'b1, 1'b0, "R9 next cycle");
    cyc(32'hA8000, 1'b0, 1'b0, 1'b1, 8'h72, 8'h40, "R9 same cycle video");
    acc(32'hA8000, 1'b0, 1'b0, "R9 next cycle video");
    cyc(32'hA8000, 1'b0, 1'b0, 1'b1, 8'h72, 8'h00, "R9 same cycle video");

    // R10: other offsets have no effect
    wr(8'h58, 8'hFF, "R10");
    wr(8'h60, 8'hFF, "R10");
    wr(8'h71, 8'hFF, "R10");
    wr(8'h73, 8'hFF, "R10");
    wr(8'hFF, 8'hFF, "R10");
    sweep("R10 after stray writes");

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      logic [7:0]  ca;
      logic        cw;
      a  = 32'h98000 + ($urandom % 32'h70000);
      cw = ($urandom % 4) == 0;
      ca = 8'h57 + 8'($urandom % 10);
      if (($urandom % 5) == 0) ca = 8'h72;
      cyc(a, 1'($urandom), 1'($urandom), cw, ca, 8'($urandom), "R9 R3 mixed");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule